// File: doc/BRIEF.md
# Complementary Address Pair Stress Tester

This block is a memory self-test engine that drives the address bus of a power-of-two memory region as hard as it can. Given a base address and a region size, it forms two word addresses whose upper and lower address halves are mirror-inverted with respect to each other. Row and column lines therefore swing in opposite directions on every access. It then writes a data word to both addresses and reads both back, again and again. The two read values are compared with each other rather than with a stored expectation.

Two address patterns are applied in turn (alternating ones and zeros, then all ones). Under each of them, two data words are applied in turn (half ones over half zeros, then alternating pairs). Every address and data pairing runs a fixed number of iterations. Each iteration first uses the data word and then its bitwise complement. The run ends with done and pass high, or at the first disagreement between the two reads, which leaves the iteration index and both read values on the status pins. A region size that is not a nonzero power of two ends the run at once with an error flag, and no access is made.

The memory side uses a request channel with valid/ready and a response channel with valid/ready. A request stays stable while req_valid is high and req_ready is low, and it transfers on the first edge where both are high. Writes get no response. After a read request has transferred, the block holds rsp_ready high and issues nothing more until one response beat arrives. So at most one read is outstanding, and the memory may stall either channel for any number of cycles.

Top module: `addr_stress_pair`

## Requirements
- R1: A start with a region size that is zero or not a power of two makes done and err_size high and pass low, and no request is issued.
- R2: Every request address minus the base is a multiple of four and smaller than the region size.
- R3: With mask = (size-1) with bits 1:0 cleared, n = the bit length of size-1, and half = mask >> (n/2), target one is base + (~(P ^ half) & mask) and target two is base + ((P ^ half) & mask), where P is the address pattern.
- R4: Address pattern 0xAAAAAAAA runs before 0xFFFFFFFF. Under each of them, data word 0xFFFF0000 runs before 0x5555AAAA.
- R5: One iteration issues, in this order: write D to target one, write D to target two, read target one, read target two, then the same four operations with ~D.
- R6: Each address and data pairing runs ITER_COUNT iterations, so a clean run issues 4 x 8 x ITER_COUNT requests and ends with done and pass high.
- R7: When the second read of a pair differs from the first, the run stops with done high and pass low. fail_iter holds the iteration index within the current pairing, fail_rd1 holds the target-one read, fail_rd2 holds the target-two read, and no further request is issued.
- R8: done stays high until the next start and is low in the cycle after that start is taken.
- R9: A request with req_valid high and req_ready low is held with unchanged address, write flag and data in the next cycle.
- R10: After reset, req_valid, done, pass and err_size are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; taken only when idle or finished |
| base_addr | input | ADDR_W | Region base address, captured at start |
| region_size | input | ADDR_W | Region size in bytes, captured at start |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Request byte address |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | High while a read response is awaited |
| rsp_rdata | input | DATA_W | Read data |
| done | output | 1 | Run finished or aborted |
| pass | output | 1 | Run finished without mismatch |
| err_size | output | 1 | Region size rejected |
| fail_iter | output | ITER_W | Iteration index of the mismatch |
| fail_rd1 | output | DATA_W | Target-one read at the mismatch |
| fail_rd2 | output | DATA_W | Target-two read at the mismatch |

## Verification
A start that is taken clears done by the following edge. A bad size raises done and err_size two edges after start is sampled, one edge to capture the size and one to judge it. A compare result, mismatch or final pass, is registered on the edge where the second read's response is accepted. The bench drives inputs and samples outputs on falling edges, so each value it reads has already settled from the preceding rising edge. Every request is checked in the half cycle before the edge that accepts it. The end-of-run flags are read only once done is seen high, and the request count is compared after that point, which shows that nothing was issued after a failure.

// File: rtl/aspt_pkg.sv
package aspt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SIZE  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } aspt_state_e;

  // step index inside one iteration: bit0 picks target, bit1 marks read,
  // bit2 selects the complemented data word
  localparam int unsigned STEPS_PER_ITER = 8;
  localparam int unsigned STEP_W         = $clog2(STEPS_PER_ITER);

endpackage

// File: rtl/aspt_addr_gen.sv
module aspt_addr_gen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  input  logic              pat_sel,
  output logic              size_ok,
  output logic [ADDR_W-1:0] tgt_one,
  output logic [ADDR_W-1:0] tgt_two
);

  localparam int unsigned NB_W = $clog2(ADDR_W + 1);
  localparam logic [ADDR_W-1:0] PAT_ALT  = {(ADDR_W/2){2'b10}};
  localparam logic [ADDR_W-1:0] PAT_ONES = '1;

  logic [ADDR_W-1:0] size_m1;
  logic [ADDR_W-1:0] word_mask;
  logic [ADDR_W-1:0] half_mask;
  logic [ADDR_W-1:0] pat;
  logic [ADDR_W-1:0] split;
  logic [NB_W-1:0]   bit_len;

  assign size_m1   = size - 1'b1;
  assign size_ok   = (size != '0) && ((size & size_m1) == '0);
  assign word_mask = size_m1 & ~ADDR_W'(3);

  always_comb begin
    bit_len = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (size_m1[i]) bit_len = NB_W'(i + 1);
    end
  end

  assign half_mask = word_mask >> (bit_len >> 1);
  assign pat       = pat_sel ? PAT_ONES : PAT_ALT;
  // bits of the pattern agree with the half mask in one target and
  // disagree in the other, so the two halves swing oppositely
  assign split     = pat ^ half_mask;
  assign tgt_one   = base + (~split & word_mask);
  assign tgt_two   = base + (split & word_mask);

endmodule

// File: rtl/aspt_seq.sv
module aspt_seq
  import aspt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ITER_COUNT = 1000000,
  parameter int unsigned ITER_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  input  logic              size_ok,
  input  logic [ADDR_W-1:0] tgt_one,
  input  logic [ADDR_W-1:0] tgt_two,
  output logic              pat_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic              pass,
  output logic              err_size,
  output logic [ITER_W-1:0] fail_iter,
  output logic [DATA_W-1:0] fail_rd1,
  output logic [DATA_W-1:0] fail_rd2
);

  localparam logic [DATA_W-1:0] DAT_HALF = {{(DATA_W/2){1'b1}}, {(DATA_W/2){1'b0}}};
  localparam logic [DATA_W-1:0] DAT_PAIR = {{(DATA_W/4){2'b01}}, {(DATA_W/4){2'b10}}};
  localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(ITER_COUNT - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS_PER_ITER - 1);

  aspt_state_e       state;
  logic [STEP_W-1:0] step;
  logic [ITER_W-1:0] iter;
  logic              data_sel;
  logic [DATA_W-1:0] rd_first;
  logic [DATA_W-1:0] dat_word;

  assign accept    = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign dat_word  = data_sel ? DAT_PAIR : DAT_HALF;
  assign req_valid = (state == ST_ISSUE);
  assign rsp_ready = (state == ST_WAIT);
  assign req_write = ~step[1];
  assign req_addr  = step[0] ? tgt_two : tgt_one;
  assign req_wdata = step[2] ? ~dat_word : dat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      step      <= '0;
      iter      <= '0;
      data_sel  <= 1'b0;
      pat_sel   <= 1'b0;
      rd_first  <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      err_size  <= 1'b0;
      fail_iter <= '0;
      fail_rd1  <= '0;
      fail_rd2  <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state     <= ST_SIZE;
            step      <= '0;
            iter      <= '0;
            data_sel  <= 1'b0;
            pat_sel   <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
            err_size  <= 1'b0;
            fail_iter <= '0;
            fail_rd1  <= '0;
            fail_rd2  <= '0;
          end
        end
        ST_SIZE: begin
          if (size_ok) begin
            state <= ST_ISSUE;
          end else begin
            state    <= ST_DONE;
            done     <= 1'b1;
            err_size <= 1'b1;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            if (req_write) step <= step + 1'b1;
            else           state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!step[0]) begin
              rd_first <= rsp_rdata;
              step     <= step + 1'b1;
              state    <= ST_ISSUE;
            end else if (rsp_rdata != rd_first) begin
              fail_iter <= iter;
              fail_rd1  <= rd_first;
              fail_rd2  <= rsp_rdata;
              done      <= 1'b1;
              state     <= ST_DONE;
            end else if (step != STEP_LAST) begin
              step  <= step + 1'b1;
              state <= ST_ISSUE;
            end else begin
              step  <= '0;
              state <= ST_ISSUE;
              if (iter == ITER_LAST) begin
                iter <= '0;
                if (!data_sel) begin
                  data_sel <= 1'b1;
                end else begin
                  data_sel <= 1'b0;
                  if (!pat_sel) begin
                    pat_sel <= 1'b1;
                  end else begin
                    done  <= 1'b1;
                    pass  <= 1'b1;
                    state <= ST_DONE;
                  end
                end
              end else begin
                iter <= iter + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_wdata))); // R9

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_size |-> (!req_valid && !pass)); // R1

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid); // R7

  AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done); // R6

  AST_FAIL_READS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass && !err_size) |-> (fail_rd1 != fail_rd2)); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept) |=> !done); // R8

endmodule

// File: rtl/addr_stress_pair.sv
module addr_stress_pair #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ITER_COUNT = 1000000,
  parameter int unsigned ITER_W     = (ITER_COUNT > 1) ? $clog2(ITER_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] region_size,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic              pass,
  output logic              err_size,
  output logic [ITER_W-1:0] fail_iter,
  output logic [DATA_W-1:0] fail_rd1,
  output logic [DATA_W-1:0] fail_rd2
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] size_q;
  logic              accept;
  logic              size_ok;
  logic              pat_sel;
  logic [ADDR_W-1:0] tgt_one;
  logic [ADDR_W-1:0] tgt_two;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (accept) begin
      base_q <= base_addr;
      size_q <= region_size;
    end
  end

  aspt_addr_gen #(
    .ADDR_W (ADDR_W)
  ) addr_gen_i (
    .base    (base_q),
    .size    (size_q),
    .pat_sel (pat_sel),
    .size_ok (size_ok),
    .tgt_one (tgt_one),
    .tgt_two (tgt_two)
  );

  aspt_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ITER_COUNT (ITER_COUNT),
    .ITER_W     (ITER_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .size_ok   (size_ok),
    .tgt_one   (tgt_one),
    .tgt_two   (tgt_two),
    .pat_sel   (pat_sel),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .done      (done),
    .pass      (pass),
    .err_size  (err_size),
    .fail_iter (fail_iter),
    .fail_rd1  (fail_rd1),
    .fail_rd2  (fail_rd2)
  );

  AST_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((((req_addr - base_q) & ADDR_W'(3)) == '0) &&
                   ((req_addr - base_q) < size_q))); // R2

endmodule

// File: tb/addr_stress_pair_tb_top.sv
module addr_stress_pair_tb_top;

  localparam int ITERS = 3;
  localparam int IW    = 2;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] size;
    logic        bp;
    logic        exp_err;
    logic        exp_pass;
    logic [31:0] t1a;
    logic [31:0] t2a;
    logic [31:0] t1b;
    logic [31:0] t2b;
    logic [31:0] f_addr;
    logic [7:0]  f_after;
    logic [7:0]  exp_reqs;
    logic [1:0]  exp_iter;
    logic [31:0] exp_rd1;
    logic [31:0] exp_rd2;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{32'h1000, 32'h100, 1'b0, 1'b0, 1'b1, 32'h1058, 32'h10A4, 32'h100C, 32'h10F0,
      32'hFFFFFFFF, 8'd0, 8'd96, 2'd0, 32'h0, 32'h0},
    '{32'h0000, 32'h040, 1'b1, 1'b0, 1'b1, 32'h0010, 32'h002C, 32'h0004, 32'h0038,
      32'hFFFFFFFF, 8'd0, 8'd96, 2'd0, 32'h0, 32'h0},
    '{32'h2000, 32'h080, 1'b1, 1'b0, 1'b1, 32'h2058, 32'h2024, 32'h200C, 32'h2070,
      32'hFFFFFFFF, 8'd0, 8'd96, 2'd0, 32'h0, 32'h0},
    '{32'h0300, 32'h004, 1'b0, 1'b0, 1'b1, 32'h0300, 32'h0300, 32'h0300, 32'h0300,
      32'hFFFFFFFF, 8'd0, 8'd96, 2'd0, 32'h0, 32'h0},
    '{32'h1000, 32'h000, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0,
      32'hFFFFFFFF, 8'd0, 8'd0, 2'd0, 32'h0, 32'h0},
    '{32'h1000, 32'h030, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0,
      32'hFFFFFFFF, 8'd0, 8'd0, 2'd0, 32'h0, 32'h0},
    '{32'h1000, 32'h100, 1'b1, 1'b0, 1'b0, 32'h1058, 32'h10A4, 32'h100C, 32'h10F0,
      32'h10A4, 8'd3, 8'd16, 2'd1, 32'h0000FFFF, 32'h0000FFFE},
    '{32'h1000, 32'h100, 1'b0, 1'b0, 1'b0, 32'h1058, 32'h10A4, 32'h100C, 32'h10F0,
      32'h10F0, 8'd0, 8'd52, 2'd0, 32'hFFFF0000, 32'hFFFF0001}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   base_addr = '0;
  logic [31:0]   region_size = '0;
  logic          req_valid, req_write, rsp_ready;
  logic          req_ready = 1'b0;
  logic [31:0]   req_addr, req_wdata;
  logic          rsp_valid = 1'b0;
  logic [31:0]   rsp_rdata = '0;
  logic          done, pass, err_size;
  logic [IW-1:0] fail_iter;
  logic [31:0]   fail_rd1, fail_rd2;

  always #5 clk = ~clk;

  addr_stress_pair #(
    .ADDR_W (32), .DATA_W (32), .ITER_COUNT (ITERS), .ITER_W (IW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start),
    .base_addr (base_addr), .region_size (region_size),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
    .done (done), .pass (pass), .err_size (err_size),
    .fail_iter (fail_iter), .fail_rd1 (fail_rd1), .fail_rd2 (fail_rd2)
  );

  int   total = 0;
  int   bad = 0;
  row_t cur;
  int   req_cnt;
  int   seq_bad;
  int   fault_reads;
  int   pend;
  logic [31:0] pend_data;
  bit   took_rsp;
  int   cyc = 0;
  logic [31:0] mem [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dword(input int dsel);
    return (dsel == 0) ? 32'hFFFF0000 : 32'h5555AAAA;
  endfunction

  // memory model and request sequence check (R3, R4, R5, R6)
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    req_cnt = 0; seq_bad = 0; fault_reads = 0; pend = 0; took_rsp = 0;
    pend_data = '0; cur = ROWS[0];
    forever begin
      @(negedge clk);
      cyc++;
      if (took_rsp) begin rsp_valid = 1'b0; took_rsp = 0; end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin rsp_valid = 1'b1; rsp_rdata = pend_data; end
      end
      if (rsp_valid && rsp_ready) took_rsp = 1;
      req_ready = cur.bp ? ((cyc % 3) != 0) : 1'b1;
      if (req_valid && req_ready) begin
        int k, combo, s, psel, dsel;
        logic [31:0] ea;
        logic [31:0] ed;
        k = req_cnt;
        combo = k / (8 * ITERS);
        s = k % 8;
        psel = combo / 2;
        dsel = combo % 2;
        if (psel == 0) ea = (s % 2 == 0) ? cur.t1a : cur.t2a;
        else           ea = (s % 2 == 0) ? cur.t1b : cur.t2b;
        ed = (s >= 4) ? ~dword(dsel) : dword(dsel);
        if (combo > 3 || req_addr !== ea || req_write !== (s % 4 < 2) ||
            (req_write && req_wdata !== ed)) begin
          seq_bad++;
          if (seq_bad <= 3)
            $display("note: request %0d addr=0x%0h wr=%0b data=0x%0h, wanted addr=0x%0h data=0x%0h",
                     k, req_addr, req_write, req_wdata, ea, ed);
        end
        req_cnt++;
        if (req_write) begin
          mem[req_addr[9:2]] = req_wdata;
        end else begin
          pend = 2;
          pend_data = mem[req_addr[9:2]];
          if (req_addr == cur.f_addr) begin
            if (fault_reads >= int'(cur.f_after)) pend_data = pend_data ^ 32'h1;
            fault_reads++;
          end
        end
      end
    end
  end

  bit hung = 0;

  task automatic run_row(input int r);
    int waited;
    @(negedge clk);
    cur = ROWS[r];
    req_cnt = 0; seq_bad = 0; fault_reads = 0;
    base_addr = cur.base;
    region_size = cur.size;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8", $sformatf("row %0d done cleared after start", r), done, 0);
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk(0, "R6", $sformatf("row %0d watchdog", r), waited, 5000);
      hung = 1;
      return;
    end
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8", $sformatf("row %0d done held", r), done, 1);
    chk(err_size == cur.exp_err, "R1", $sformatf("row %0d err_size", r), err_size, cur.exp_err);
    chk(pass == cur.exp_pass, "R6", $sformatf("row %0d pass", r), pass, cur.exp_pass);
    chk(req_cnt == int'(cur.exp_reqs), "R7", $sformatf("row %0d request count", r),
        req_cnt, cur.exp_reqs);
    chk(seq_bad == 0, "R5", $sformatf("row %0d request order/addresses (R3 R4)", r), seq_bad, 0);
    if (!cur.exp_pass && !cur.exp_err) begin
      chk(fail_iter == cur.exp_iter, "R7", $sformatf("row %0d fail_iter", r), fail_iter, cur.exp_iter);
      chk(fail_rd1 == cur.exp_rd1, "R7", $sformatf("row %0d fail_rd1", r), fail_rd1, cur.exp_rd1);
      chk(fail_rd2 == cur.exp_rd2, "R7", $sformatf("row %0d fail_rd2", r), fail_rd2, cur.exp_rd2);
    end
  endtask

  // R2 observed at the ports during every run
  int r2_bad = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid && !err_size) begin
        if (((req_addr - cur.base) & 32'h3) != 0 || (req_addr - cur.base) >= cur.size)
          r2_bad++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R10", "reset req_valid", req_valid, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
    chk(pass == 1'b0, "R10", "reset pass", pass, 0);
    chk(err_size == 1'b0, "R10", "reset err_size", err_size, 0);
    rst_n = 1'b1;
    for (int r = 0; r < NROWS; r++) begin
      if (!hung) run_row(r);
    end
    chk(r2_bad == 0, "R2", "addresses aligned and inside region", r2_bad, 0);
    // R9: a stalled request is checked by AST_REQ_HOLD; rows 1, 2, 5, 6 stall req_ready
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL R6 global watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule